// File: doc/BRIEF.md
# DMA Descriptor Ring Sequencer

This block walks a table of 64-bit DMA descriptors held in local RAM and feeds them, one at a time, to a separate transfer engine. A host port writes entries into the table at any time. A one-cycle start pulse begins a run at a chosen start index. For each entry the sequencer reads the descriptor and checks its valid flag. If the flag is set, it presents the buffer address and byte length to the engine and holds the request until the engine answers with a one-cycle done.

After completion the sequencer looks at the descriptor's interrupt and wrap flags. It raises a one-cycle interrupt if asked. The next index is either the latched start index (wrap) or the following entry. The run ends on the first entry whose valid flag is clear.

The control is a five-state machine:
- IDLE: waits for start. On a start pulse it latches the start index and moves to FETCH.
- FETCH: issues a table read and moves to LOAD.
- LOAD: captures the returned descriptor. It goes to XFER when the entry is valid, or back to IDLE (halt) when it is not.
- XFER: holds the request. It moves to FINISH on done.
- FINISH: pulses the interrupt if flagged, steps the index and returns to FETCH.

The table depth is 2**IDX_W entries. IDX_W=13 gives the full 8192-entry, 64 KiB window, where entry index = byte offset / 8.

Top module: `dring_top`

## Requirements
- R1: After reset every table entry reads as all zeros, so a run started on an unwritten entry halts without any transfer request.
- R2: Descriptor layout: bits 31:0 are the buffer address, presented on `xfer_addr`. Bits 55:32 are the 24-bit length, presented on `xfer_len`. Bits 60:56 are ignored.
- R3: On a start pulse in IDLE, the first descriptor fetched is the one at `cfg_start_idx`, which is latched at that moment.
- R4: The valid flag (bit 62) is checked before a transfer. When it is clear, the sequencer returns to IDLE and raises no request.
- R5: `xfer_req` stays high with stable address and length until `xfer_done` is seen, and drops the cycle after.
- R6: When the interrupt flag (bit 63) is set, `irq` is high for exactly one cycle, the cycle after `xfer_done`. It stays low for descriptors without the flag.
- R7: When the wrap flag (bit 61) is set, the next entry is the latched start index. A start pulse or a `cfg_start_idx` change while busy has no effect on the run.
- R8: Without wrap, the index advances by one, and the last entry rolls over to entry 0.
- R9: Table writes during a transfer do not change the descriptor in flight. They are seen on that entry's next fetch.
- R10: `busy` is high from the cycle after the start pulse until the halt, and `xfer_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Entry index written |
| tbl_wr_data | input | 64 | Descriptor value written |
| cfg_start_idx | input | IDX_W | Start index, latched on start |
| start | input | 1 | One-cycle run start pulse |
| busy | output | 1 | Run in progress |
| xfer_req | output | 1 | Transfer request to engine |
| xfer_addr | output | 32 | Buffer address of request |
| xfer_len | output | 24 | Byte length of request |
| xfer_done | input | 1 | One-cycle completion from engine |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with IDX_W=4, a 16-entry table. With that depth, rollover from the last entry to entry 0 is reached within a three-descriptor chain, and chains at a non-zero start index, single-entry wrap loops and halts on unwritten entries all fit in a few hundred cycles. Tearing and start-while-busy are provoked by table writes and start pulses issued while the request is held.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;
    localparam int DESC_W = 64;

    // Bit positions are fixed by the descriptor layout.
    typedef struct packed {
        logic              irq;    // 63
        logic              valid;  // 62
        logic              wrap;   // 61
        logic [4:0]        rsvd;   // 60:56
        logic [LEN_W-1:0]  len;    // 55:32
        logic [ADDR_W-1:0] addr;   // 31:0
    } desc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_LOAD,
        S_XFER,
        S_FINISH
    } seq_state_t;

endpackage

// File: rtl/dring_table.sv
module dring_table
    import dring_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DESC_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DESC_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  written;
    logic [DESC_W-1:0] rd_q;

    // Storage carries no reset; the written mask makes unwritten entries read zero.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            written <= '0;
        end else if (wr_en) begin
            written[wr_idx] <= 1'b1;
        end
    end

    // Synchronous read returns the contents from before any same-cycle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= written[rd_idx] ? mem[rd_idx] : '0;
        end
    end

    assign rd_data = desc_t'(rd_q);

    AST_FRESH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $past(rd_en) && !written[$past(rd_idx)]
         && $past(written) == written) |-> rd_q == '0); // R1

endmodule

// File: rtl/dring_index.sv
module dring_index #(
    parameter int IDX_W = 11
) (
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             wrap,
    output logic [IDX_W-1:0] next_idx
);

    // Plain increment rolls over naturally at 2**IDX_W.
    logic [IDX_W-1:0] step_idx;

    always_comb begin
        step_idx = cur_idx + 1'b1;
        next_idx = wrap ? start_idx : step_idx;
    end

endmodule

// File: rtl/dring_fsm.sv
module dring_fsm
    import dring_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  cfg_start_idx,
    input  logic              xfer_done,
    input  desc_t             rd_data,
    input  logic [IDX_W-1:0]  next_idx,
    output logic              rd_en,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [IDX_W-1:0]  start_q,
    output logic              wrap_q,
    output logic              busy,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              irq
);

    seq_state_t state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              irq_q;

    logic unused_rsvd;
    assign unused_rsvd = &{1'b0, rd_data.rsvd};

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (start) nxt = S_FETCH;
            S_FETCH:  nxt = S_LOAD;
            S_LOAD:   nxt = rd_data.valid ? S_XFER : S_IDLE;
            S_XFER:   if (xfer_done) nxt = S_FINISH;
            S_FINISH: nxt = S_FETCH;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register and the data latched alongside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cur_idx <= '0;
            start_q <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            wrap_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start) begin
                cur_idx <= cfg_start_idx;
                start_q <= cfg_start_idx;
            end
            if (state == S_LOAD) begin
                addr_q <= rd_data.addr;
                len_q  <= rd_data.len;
                wrap_q <= rd_data.wrap;
                irq_q  <= rd_data.irq;
            end
            if (state == S_FINISH) begin
                cur_idx <= next_idx;
            end
        end
    end

    // Outputs.
    always_comb begin
        rd_en     = (state == S_FETCH);
        busy      = (state != S_IDLE);
        xfer_req  = (state == S_XFER);
        xfer_addr = addr_q;
        xfer_len  = len_q;
        irq       = (state == S_FINISH) && irq_q;
    end

    AST_HALT_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && !rd_data.valid) |=> (state == S_IDLE && !xfer_req)); // R4

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len))); // R5

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_done) |=> !xfer_req); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(xfer_done) && $past(xfer_req))); // R6

    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FINISH && wrap_q) |=> cur_idx == start_q); // R7

    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(start_q)); // R7

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FINISH && !wrap_q) |=> cur_idx == IDX_W'($past(cur_idx) + 1'b1)); // R8

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_req); // R10

endmodule

// File: rtl/dring_top.sv
module dring_top
    import dring_pkg::*;
#(
    parameter int IDX_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic [63:0]       tbl_wr_data,
    input  logic [IDX_W-1:0]  cfg_start_idx,
    input  logic              start,
    output logic              busy,
    output logic              xfer_req,
    output logic [31:0]       xfer_addr,
    output logic [23:0]       xfer_len,
    input  logic              xfer_done,
    output logic              irq
);

    logic             rd_en;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] start_q;
    logic [IDX_W-1:0] next_idx;
    logic             wrap_q;
    desc_t            rd_data;

    dring_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr_en),
        .wr_idx  (tbl_wr_idx),
        .wr_data (tbl_wr_data),
        .rd_en   (rd_en),
        .rd_idx  (cur_idx),
        .rd_data (rd_data)
    );

    dring_index #(.IDX_W(IDX_W)) u_index (
        .cur_idx   (cur_idx),
        .start_idx (start_q),
        .wrap      (wrap_q),
        .next_idx  (next_idx)
    );

    dring_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cfg_start_idx (cfg_start_idx),
        .xfer_done     (xfer_done),
        .rd_data       (rd_data),
        .next_idx      (next_idx),
        .rd_en         (rd_en),
        .cur_idx       (cur_idx),
        .start_q       (start_q),
        .wrap_q        (wrap_q),
        .busy          (busy),
        .xfer_req      (xfer_req),
        .xfer_addr     (xfer_addr),
        .xfer_len      (xfer_len),
        .irq           (irq)
    );

endmodule

// File: tb/tb_dring_top.sv
module tb_dring_top;

    localparam int CLK_P = 10;
    localparam int IDX_W = 4;

    // Chain written at entries 2..6; the last value is invalid and ends the run.
    localparam logic [63:0] CHAIN [5] = '{
        64'h4000_0020_0000_1000,
        64'hC000_0030_0000_2000,
        64'h4000_0201_0000_8000,
        64'h5FFF_FFFF_FFFF_FFFC,
        64'h0000_0000_0000_0000
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tbl_wr_en = 1'b0;
    logic [IDX_W-1:0]  tbl_wr_idx = '0;
    logic [63:0]       tbl_wr_data = '0;
    logic [IDX_W-1:0]  cfg_start_idx = '0;
    logic              start = 1'b0;
    logic              busy;
    logic              xfer_req;
    logic [31:0]       xfer_addr;
    logic [23:0]       xfer_len;
    logic              xfer_done = 1'b0;
    logic              irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dring_top #(.IDX_W(IDX_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tbl_wr_en     (tbl_wr_en),
        .tbl_wr_idx    (tbl_wr_idx),
        .tbl_wr_data   (tbl_wr_data),
        .cfg_start_idx (cfg_start_idx),
        .start         (start),
        .busy          (busy),
        .xfer_req      (xfer_req),
        .xfer_addr     (xfer_addr),
        .xfer_len      (xfer_len),
        .xfer_done     (xfer_done),
        .irq           (irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [IDX_W-1:0] idx, input logic [63:0] val);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_data = val;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic pulse_start(input logic [IDX_W-1:0] idx);
        cfg_start_idx = idx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // poke: 0 none, 1 table write during hold, 2 start pulse during hold
    task automatic expect_xfer(input logic [31:0] ea, input logic [23:0] el, input bit ei,
                               input int poke, input logic [IDX_W-1:0] pidx, input logic [63:0] pval);
        int k = 0;
        while (!xfer_req && k < 40) begin @(negedge clk); k++; end
        chk(xfer_req, "R4 valid entry must raise request", 64'(xfer_req), 64'd1);
        if (!xfer_req) return;
        chk(xfer_addr == ea, "R2 address field", 64'(xfer_addr), 64'(ea));
        chk(xfer_len == el, "R2 length field", 64'(xfer_len), 64'(el));
        if (poke == 1) begin
            host_write(pidx, pval);
            chk(xfer_addr == ea && xfer_len == el, "R9 in-flight descriptor kept",
                64'(xfer_addr), 64'(ea));
        end else if (poke == 2) begin
            pulse_start(pidx);
            chk(xfer_addr == ea, "R7 start while busy ignored", 64'(xfer_addr), 64'(ea));
        end else begin
            @(negedge clk);
        end
        chk(xfer_req == 1'b1, "R5 request held until done", 64'(xfer_req), 64'd1);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        chk(irq == ei, "R6 interrupt after done", 64'(irq), 64'(ei));
        chk(xfer_req == 1'b0, "R5 request drops after done", 64'(xfer_req), 64'd0);
        @(negedge clk);
        chk(irq == 1'b0, "R6 interrupt lasts one cycle", 64'(irq), 64'd0);
    endtask

    task automatic expect_halt(input string req);
        int k = 0;
        int seen = 0;
        while (busy && k < 12) begin
            if (xfer_req) seen++;
            @(negedge clk); k++;
        end
        chk(busy == 1'b0, {req, " run halts (R10)"}, 64'(busy), 64'd0);
        chk(seen == 0, {req, " no request on invalid entry (R4)"}, 64'(seen), 64'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000 && !finished) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=done", cyc);
                $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk(busy == 1'b0, "R10 idle after reset", 64'(busy), 64'd0);
        chk(xfer_req == 1'b0, "R10 no request after reset", 64'(xfer_req), 64'd0);
        chk(irq == 1'b0, "R6 no interrupt after reset", 64'(irq), 64'd0);

        // R1: unwritten entry reads zero, so the run halts at once
        pulse_start(4'd0);
        chk(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
        expect_halt("R1");

        // R3/R2/R6/R8 vector chain from entry 2; start pulse while busy ignored (R7)
        for (int i = 0; i < 5; i++) host_write(IDX_W'(2 + i), CHAIN[i]);
        pulse_start(4'd2);
        for (int i = 0; i < 5; i++) begin
            if (!CHAIN[i][62]) break;
            expect_xfer(CHAIN[i][31:0], CHAIN[i][55:32], CHAIN[i][63],
                        (i == 0) ? 2 : 0, 4'd9, 64'd0);
        end
        expect_halt("R4 chain end");

        // R7 single wrapping entry at 9 loops; R9 write during the last pass
        host_write(4'd9, 64'h6000_0010_0000_A000);
        host_write(4'd10, 64'h4000_0044_0000_B000);
        pulse_start(4'd9);
        expect_xfer(32'h0000_A000, 24'h10, 1'b0, 0, 4'd0, 64'd0);
        expect_xfer(32'h0000_A000, 24'h10, 1'b0, 2, 4'd2, 64'd0);
        expect_xfer(32'h0000_A000, 24'h10, 1'b0, 1, 4'd9, 64'd0);
        expect_halt("R9 rewritten entry seen on next fetch");

        // R8 rollover from the last entry to entry 0
        host_write(4'd14, 64'h4000_0001_0000_0E00);
        host_write(4'd15, 64'hC000_0002_0000_0F00);
        host_write(4'd0,  64'h4000_0003_0000_0000);
        pulse_start(4'd14);
        expect_xfer(32'h0000_0E00, 24'h1, 1'b0, 0, 4'd0, 64'd0);
        expect_xfer(32'h0000_0F00, 24'h2, 1'b1, 0, 4'd0, 64'd0);
        expect_xfer(32'h0000_0000, 24'h3, 1'b0, 0, 4'd0, 64'd0);
        expect_halt("R8 rollover");

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule